// File: doc/BRIEF.md
# DDR command legality checker

This block sits beside a DDR SDRAM command bus and judges every command against the state of the four banks. On each rising clock edge it samples the clock enable, the chip select, the row strobe, the column strobe, the write enable, the bank address and the auto-precharge address bit. From these it forms one command. It then compares that command with the state of the bank it targets, or of all banks for the commands that act on all of them. The result is a two-bit verdict, and each bank's state is updated to follow the command.

Each bank is modelled as idle, active, reading, writing or precharging. A bank that is reading, writing or precharging runs a down-counter, so the block also follows burst ends, auto-precharge and write recovery without further commands. The burst length, the write recovery count and the precharge count come in as static inputs.

The block only watches the bus: it never drives it. It is meant for simulation monitors and for on-chip protocol watchdogs.

Top module: `ddr_cmd_legality`

## Requirements
- R1: While rst_ni is low, every bank is idle (state code 0) and verdict_o reads 01 (no-operation).
- R2: The verdict for the command sampled at edge n appears on verdict_o after edge n and is 00 legal, 01 no-operation or 10 illegal. A cycle with cs_ni high, or the NOP pin pattern, gives 01. An illegal command changes no bank. Per-bank state codes: 0 idle, 1 active, 2 reading, 3 writing, 4 precharging. Bank b sits in bank_state_o[3b+2:3b].
- R3: With cke_i high and cs_ni low, the pin triple {ras_ni,cas_ni,we_ni} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, 110 burst stop, 111 NOP.
- R4: Activate is legal only for an idle bank, which then becomes active. For any other bank it is illegal.
- R5: Read is legal for an active bank, and for a reading or writing bank with no auto-precharge pending. The bank reads for burst_len_i/2 cycles and then becomes active, or begins precharge if ap_i was high. A read to a bank whose write with auto-precharge is still in progress is illegal.
- R6: Write is legal for an active bank, and for a writing bank with no auto-precharge pending. It is illegal for a reading bank.
- R7: A write with ap_i high sampled at edge n leaves the bank writing until edge n + burst_len_i/2 + 1 + t_wr_i, when precharging starts. The bank becomes idle t_rp_i edges after that.
- R8: Precharge with ap_i low targets one bank. It is illegal when that bank is writing or has auto-precharge pending. Otherwise it is legal: it ends a read, moves an active bank to precharging, and leaves an idle or precharging bank as it is.
- R9: Precharge with ap_i high ignores ba_i and acts on all banks. It is illegal if any bank is writing or has auto-precharge pending. Otherwise every active or reading bank starts precharging.
- R10: Burst stop is legal only while at least one bank reads without auto-precharge and no bank writes or reads with auto-precharge. Reading banks then become active. Otherwise it is illegal.
- R11: Refresh and mode register set are legal only when all banks are idle.
- R12: cke_i low is illegal while any bank is reading or writing. Otherwise it is legal. Either way it changes no bank.
- R13: A command that arrives on the same edge at which a bank's counter expires is judged on the state before the expiry, while the expiry still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| ap_i | input | 1 | Auto-precharge / all-banks address bit |
| burst_len_i | input | 4 | Burst length in beats (2, 4 or 8) |
| t_wr_i | input | 4 | Write recovery in cycles |
| t_rp_i | input | 4 | Precharge time in cycles (0 treated as 1) |
| verdict_o | output | 2 | Registered verdict of the last command |
| bank_state_o | output | 12 | Packed state codes of the four banks |

## Verification
A new command and a bank's own counter expiry can land on the same edge, for example at the end of write recovery or of precharge. The bench provokes this by issuing an activate on exactly the edge at which a precharging bank's counter runs out. It expects an illegal verdict, yet the bank must still show idle after that edge. The same timing is tested at the end of a write with auto-precharge, where a read issued just before precharge starts must be refused.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;
  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_ACTIVE = 3'd1,
    BK_READ   = 3'd2,
    BK_WRITE  = 3'd3,
    BK_PRECH  = 3'd4
  } bank_st_e;

  typedef enum logic [3:0] {
    C_CKE_LOW, C_DESEL, C_NOP, C_ACT, C_READ, C_WRITE,
    C_PRE, C_PALL, C_REF, C_MRS, C_BST
  } cmd_e;

  typedef enum logic [2:0] {
    A_NONE, A_ACT, A_READ, A_WRITE, A_PRE, A_STOP
  } bank_act_e;

  typedef enum logic [1:0] {
    V_LEGAL   = 2'b00,
    V_NOP     = 2'b01,
    V_ILLEGAL = 2'b10
  } verdict_e;

  localparam int unsigned ST_W = 3;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ap_i,
  output cmd_e cmd_o
);
  // R3 pin table
  always_comb begin
    if (!cke_i) begin
      cmd_o = C_CKE_LOW;
    end else if (cs_ni) begin
      cmd_o = C_DESEL;
    end else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = C_ACT;
        3'b101:  cmd_o = C_READ;
        3'b100:  cmd_o = C_WRITE;
        3'b010:  cmd_o = ap_i ? C_PALL : C_PRE;
        3'b001:  cmd_o = C_REF;
        3'b000:  cmd_o = C_MRS;
        3'b110:  cmd_o = C_BST;
        default: cmd_o = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_cmd_judge.sv
module ddr_cmd_judge
  import ddr_chk_pkg::*;
#(
  parameter  int NB  = 4,
  localparam int BAW = $clog2(NB)
) (
  input  cmd_e            cmd_i,
  input  logic [BAW-1:0]  ba_i,
  input  bank_st_e        st_i [NB],
  input  logic [NB-1:0]   ap_pend_i,
  output verdict_e        verdict_o,
  output bank_act_e       act_o [NB]
);
  logic     any_rd, any_wr, any_ap, rd_ap, all_idle;
  bank_st_e tgt_st;
  logic     tgt_ap;

  always_comb begin
    any_rd   = 1'b0;
    any_wr   = 1'b0;
    any_ap   = 1'b0;
    rd_ap    = 1'b0;
    all_idle = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (st_i[b] == BK_READ)  any_rd = 1'b1;
      if (st_i[b] == BK_WRITE) any_wr = 1'b1;
      if (st_i[b] != BK_IDLE)  all_idle = 1'b0;
      if (ap_pend_i[b])        any_ap = 1'b1;
      if (st_i[b] == BK_READ && ap_pend_i[b]) rd_ap = 1'b1;
    end
  end

  assign tgt_st = st_i[ba_i];
  assign tgt_ap = ap_pend_i[ba_i];

  always_comb begin
    verdict_o = V_ILLEGAL;
    for (int b = 0; b < NB; b++) act_o[b] = A_NONE;
    case (cmd_i)
      C_CKE_LOW: verdict_o = (any_rd || any_wr) ? V_ILLEGAL : V_LEGAL; // R12
      C_DESEL, C_NOP: verdict_o = V_NOP;
      C_ACT: if (tgt_st == BK_IDLE) begin
        verdict_o    = V_LEGAL;
        act_o[ba_i]  = A_ACT;
      end
      C_READ: if (tgt_st == BK_ACTIVE ||
                  ((tgt_st == BK_READ || tgt_st == BK_WRITE) && !tgt_ap)) begin
        verdict_o    = V_LEGAL;
        act_o[ba_i]  = A_READ;
      end
      C_WRITE: if (tgt_st == BK_ACTIVE || (tgt_st == BK_WRITE && !tgt_ap)) begin
        verdict_o    = V_LEGAL;
        act_o[ba_i]  = A_WRITE;
      end
      C_PRE: if (tgt_st != BK_WRITE && !tgt_ap) begin
        verdict_o = V_LEGAL;
        if (tgt_st == BK_ACTIVE || tgt_st == BK_READ) act_o[ba_i] = A_PRE;
      end
      C_PALL: if (!any_wr && !any_ap) begin
        verdict_o = V_LEGAL;
        for (int b = 0; b < NB; b++)
          if (st_i[b] == BK_ACTIVE || st_i[b] == BK_READ) act_o[b] = A_PRE;
      end
      C_REF, C_MRS: if (all_idle) verdict_o = V_LEGAL;
      C_BST: if (any_rd && !rd_ap && !any_wr) begin
        verdict_o = V_LEGAL;
        for (int b = 0; b < NB; b++)
          if (st_i[b] == BK_READ) act_o[b] = A_STOP;
      end
      default: verdict_o = V_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_chk_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bank_act_e     act_i,
  input  logic          ap_i,
  input  logic [CW-1:0] half_i,
  input  logic [CW-1:0] wrec_i,
  input  logic [CW-1:0] trp_i,
  output bank_st_e      st_o,
  output logic          ap_o
);
  bank_st_e      st_q, st_d;
  logic          ap_q, ap_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    ap_d  = ap_q;
    cnt_d = cnt_q;
    case (act_i)
      A_ACT: st_d = BK_ACTIVE;
      A_READ: begin
        st_d  = BK_READ;
        ap_d  = ap_i;
        cnt_d = half_i;
      end
      A_WRITE: begin
        st_d  = BK_WRITE;
        ap_d  = ap_i;
        cnt_d = ap_i ? wrec_i : half_i; // R7 recovery folded into the burst
      end
      A_PRE: begin
        st_d  = BK_PRECH;
        ap_d  = 1'b0;
        cnt_d = trp_i;
      end
      A_STOP: begin
        st_d  = BK_ACTIVE;
        ap_d  = 1'b0;
        cnt_d = '0;
      end
      default: begin
        if (st_q == BK_READ || st_q == BK_WRITE || st_q == BK_PRECH) begin
          if (cnt_q <= CW'(1)) begin
            if (st_q == BK_PRECH) begin
              st_d  = BK_IDLE;
              cnt_d = '0;
            end else if (ap_q) begin
              st_d  = BK_PRECH;
              ap_d  = 1'b0;
              cnt_d = trp_i;
            end else begin
              st_d  = BK_ACTIVE;
              cnt_d = '0;
            end
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      ap_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      ap_q  <= ap_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o = st_q;
  assign ap_o = ap_q;
endmodule

// File: rtl/ddr_cmd_legality.sv
module ddr_cmd_legality
  import ddr_chk_pkg::*;
#(
  parameter  int NB  = 4,
  parameter  int BLW = 4,
  parameter  int TW  = 4,
  localparam int BAW = $clog2(NB),
  localparam int CW  = ((BLW > TW) ? BLW : TW) + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [BAW-1:0]   ba_i,
  input  logic             ap_i,
  input  logic [BLW-1:0]   burst_len_i,
  input  logic [TW-1:0]    t_wr_i,
  input  logic [TW-1:0]    t_rp_i,
  output logic [1:0]       verdict_o,
  output logic [NB*ST_W-1:0] bank_state_o
);
  cmd_e          cmd;
  bank_st_e      st [NB];
  logic [NB-1:0] ap_pend;
  bank_act_e     act [NB];
  verdict_e      verdict_d, verdict_q;

  logic [CW-1:0] half_raw, half, wrec, trp;

  assign half_raw = CW'(burst_len_i >> 1);
  assign half     = (half_raw == '0) ? CW'(1) : half_raw;
  assign wrec     = half + CW'(1) + CW'(t_wr_i);
  assign trp      = (t_rp_i == '0) ? CW'(1) : CW'(t_rp_i);

  ddr_cmd_decode u_decode (
    .cke_i  (cke_i),
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .ap_i   (ap_i),
    .cmd_o  (cmd)
  );

  ddr_cmd_judge #(.NB(NB)) u_judge (
    .cmd_i     (cmd),
    .ba_i      (ba_i),
    .st_i      (st),
    .ap_pend_i (ap_pend),
    .verdict_o (verdict_d),
    .act_o     (act)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ddr_bank_fsm #(.CW(CW)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (act[b]),
      .ap_i   (ap_i),
      .half_i (half),
      .wrec_i (wrec),
      .trp_i  (trp),
      .st_o   (st[b]),
      .ap_o   (ap_pend[b])
    );
    assign bank_state_o[b*ST_W +: ST_W] = st[b];
  end

  // R2 verdict registered one cycle after the command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) verdict_q <= V_NOP;
    else         verdict_q <= verdict_d;
  end

  assign verdict_o = verdict_q;
endmodule

// File: rtl/ddr_cmd_legality_sva.sv
module ddr_cmd_legality_sva #(
  parameter  int NB  = 4,
  localparam int BAW = $clog2(NB),
  localparam int SW  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cke_i,
  input logic             cs_ni,
  input logic             ras_ni,
  input logic             cas_ni,
  input logic             we_ni,
  input logic [BAW-1:0]   ba_i,
  input logic             ap_i,
  input logic [1:0]       verdict_o,
  input logic [NB*SW-1:0] bank_state_o
);
  logic           any_rd, any_wr, all_idle, idle_or_act, idle_or_pre;
  logic [SW-1:0]  tgt_st;
  logic [BAW-1:0] ba_q;
  logic           sel, act_c, pall_c, mrs_ref_c, bst_c;

  always_comb begin
    any_rd = 1'b0; any_wr = 1'b0; all_idle = 1'b1;
    idle_or_act = 1'b1; idle_or_pre = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (bank_state_o[b*SW +: SW] == 3'd2) any_rd = 1'b1;
      if (bank_state_o[b*SW +: SW] == 3'd3) any_wr = 1'b1;
      if (bank_state_o[b*SW +: SW] != 3'd0) all_idle = 1'b0;
      if (bank_state_o[b*SW +: SW] > 3'd1) idle_or_act = 1'b0;
      if (bank_state_o[b*SW +: SW] != 3'd0 && bank_state_o[b*SW +: SW] != 3'd4)
        idle_or_pre = 1'b0;
    end
  end

  assign tgt_st    = bank_state_o[ba_i*SW +: SW];
  assign sel       = cke_i && !cs_ni;
  assign act_c     = sel && {ras_ni, cas_ni, we_ni} == 3'b011;
  assign pall_c    = sel && {ras_ni, cas_ni, we_ni} == 3'b010 && ap_i;
  assign mrs_ref_c = sel && !ras_ni && !cas_ni;
  assign bst_c     = sel && {ras_ni, cas_ni, we_ni} == 3'b110;

  always_ff @(posedge clk_i) ba_q <= ba_i;

  AST_VERDICT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_o != 2'b11); // R2
  AST_DESEL_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cs_ni) |=> verdict_o == 2'b01); // R2
  AST_ACT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_c && tgt_st == 3'd0) |=> (verdict_o == 2'b00 && bank_state_o[ba_q*SW +: SW] == 3'd1)); // R4
  AST_ACT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_c && tgt_st != 3'd0) |=> verdict_o == 2'b10); // R4
  AST_PALL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pall_c && idle_or_act) |=> (verdict_o == 2'b00 && idle_or_pre)); // R9
  AST_BST_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_c && any_wr) |=> verdict_o == 2'b10); // R10
  AST_BUSY_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrs_ref_c && !all_idle) |=> verdict_o == 2'b10); // R11
  AST_CKE_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && (any_rd || any_wr)) |=> verdict_o == 2'b10); // R12
endmodule

bind ddr_cmd_legality ddr_cmd_legality_sva #(.NB(NB)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cke_i        (cke_i),
  .cs_ni        (cs_ni),
  .ras_ni       (ras_ni),
  .cas_ni       (cas_ni),
  .we_ni        (we_ni),
  .ba_i         (ba_i),
  .ap_i         (ap_i),
  .verdict_o    (verdict_o),
  .bank_state_o (bank_state_o)
);

// File: tb/ddr_cmd_legality_tb.sv
module ddr_cmd_legality_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 0, VN = 1, VI = 2;
  localparam int S_IDLE = 0, S_ACT = 1, S_RD = 2, S_WR = 3, S_PR = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]  ba_i = '0;
  logic        ap_i = 1'b0;
  logic [3:0]  burst_len_i = 4'd4;
  logic [3:0]  t_wr_i = 4'd2;
  logic [3:0]  t_rp_i = 4'd3;
  logic [1:0]  verdict_o;
  logic [11:0] bank_state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ddr_cmd_legality u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .ap_i(ap_i),
    .burst_len_i(burst_len_i), .t_wr_i(t_wr_i), .t_rp_i(t_rp_i),
    .verdict_o(verdict_o), .bank_state_o(bank_state_o)
  );

  function automatic int bk(input int b);
    return int'(bank_state_o[b*3 +: 3]);
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic cmd(input logic cke, cs, ras, cas, we, input int b, input logic ap);
    @(negedge clk_i);
    cke_i = cke; cs_ni = cs; ras_ni = ras; cas_ni = cas; we_ni = we;
    ba_i = b[1:0]; ap_i = ap;
    @(posedge clk_i);
    #1;
  endtask

  task automatic nop();                    cmd(1, 0, 1, 1, 1, 0, 0);  endtask
  task automatic desel();                  cmd(1, 1, 1, 1, 1, 0, 0);  endtask
  task automatic ckel();                   cmd(0, 1, 1, 1, 1, 0, 0);  endtask
  task automatic act(input int b);         cmd(1, 0, 0, 1, 1, b, 0);  endtask
  task automatic rd(input int b, input logic ap); cmd(1, 0, 1, 0, 1, b, ap); endtask
  task automatic wr(input int b, input logic ap); cmd(1, 0, 1, 0, 0, b, ap); endtask
  task automatic pre(input int b);         cmd(1, 0, 0, 1, 0, b, 0);  endtask
  task automatic pall(input int b);        cmd(1, 0, 0, 1, 0, b, 1);  endtask
  task automatic refr();                   cmd(1, 0, 0, 0, 1, 0, 0);  endtask
  task automatic mrs();                    cmd(1, 0, 0, 0, 0, 0, 0);  endtask
  task automatic bstop();                  cmd(1, 0, 1, 1, 0, 0, 0);  endtask

  task automatic do_reset();
    @(negedge clk_i);
    cke_i = 1; cs_ni = 0; ras_ni = 1; cas_ni = 1; we_ni = 1; ap_i = 0; ba_i = 0;
    rst_ni = 1'b0;
    @(posedge clk_i);
    #1;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    for (int b = 0; b < 4; b++) chk("R1", "bank idle in reset", bk(b), S_IDLE);
    chk("R1", "verdict in reset", verdict_o, VN);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_desel_nop();
    do_reset();
    desel(); chk("R2", "deselect verdict", verdict_o, VN);
    nop();   chk("R3", "nop verdict", verdict_o, VN);
    act(0);  chk("R3", "act decode verdict", verdict_o, VL);
    desel(); chk("R2", "deselect keeps bank", bk(0), S_ACT);
  endtask

  task automatic t_read_flow();
    do_reset();
    act(0);
    rd(0, 0); chk("R5", "read verdict", verdict_o, VL);
              chk("R5", "reading state", bk(0), S_RD);
    nop();    chk("R5", "still reading", bk(0), S_RD);
    nop();    chk("R5", "burst end active", bk(0), S_ACT);
    rd(0, 1); chk("R5", "read ap verdict", verdict_o, VL);
    nop();
    nop();    chk("R5", "read ap precharges", bk(0), S_PR);
    nop(); nop();
    nop();    chk("R5", "read ap idle", bk(0), S_IDLE);
  endtask

  task automatic t_act_busy();
    do_reset();
    act(1);  chk("R4", "act idle", bk(1), S_ACT);
    act(1);  chk("R4", "act on active verdict", verdict_o, VI);
             chk("R4", "act on active keeps", bk(1), S_ACT);
  endtask

  task automatic t_write_rules();
    do_reset();
    act(0);
    wr(0, 0); chk("R6", "write verdict", verdict_o, VL);
              chk("R6", "writing state", bk(0), S_WR);
    rd(0, 0); chk("R5", "read ends write", verdict_o, VL);
              chk("R5", "read after write", bk(0), S_RD);
    wr(0, 0); chk("R6", "write during read", verdict_o, VI);
              chk("R6", "still reading", bk(0), S_RD);
    nop();    chk("R6", "read end active", bk(0), S_ACT);
  endtask

  task automatic t_write_ap();
    do_reset();
    act(1);
    wr(1, 1); chk("R7", "write ap verdict", verdict_o, VL);
    nop(); nop();
    rd(1, 0); chk("R5", "read into write ap", verdict_o, VI);
              chk("R5", "still writing", bk(1), S_WR);
    nop();    chk("R7", "writing before tWR end", bk(1), S_WR);
    nop();    chk("R7", "precharge starts", bk(1), S_PR);
    act(1);   chk("R4", "act while precharging", verdict_o, VI);
    nop();
    act(1);   chk("R13", "act at expiry edge", verdict_o, VI);
              chk("R13", "expiry still happens", bk(1), S_IDLE);
    act(1);   chk("R4", "act after idle", verdict_o, VL);
  endtask

  task automatic t_pre();
    do_reset();
    act(0); rd(0, 0);
    pre(0);   chk("R8", "pre ends read", verdict_o, VL);
              chk("R8", "read to precharge", bk(0), S_PR);
    act(2); wr(2, 0);
    pre(2);   chk("R8", "pre during write", verdict_o, VI);
              chk("R8", "write kept", bk(2), S_WR);
    pre(3);   chk("R8", "pre idle bank", verdict_o, VL);
              chk("R8", "idle bank kept", bk(3), S_IDLE);
  endtask

  task automatic t_pall();
    do_reset();
    act(0); act(1); act(2); rd(2, 0);
    pall(1);  chk("R9", "pall verdict", verdict_o, VL);
    for (int b = 0; b < 3; b++) chk("R9", "bank precharging", bk(b), S_PR);
    chk("R9", "idle bank stays", bk(3), S_IDLE);
    do_reset();
    act(0); act(3); wr(3, 0);
    pall(0);  chk("R9", "pall during write", verdict_o, VI);
              chk("R9", "other bank kept", bk(0), S_ACT);
  endtask

  task automatic t_bst();
    do_reset();
    bstop();  chk("R10", "stop with no read", verdict_o, VI);
    act(0); rd(0, 0);
    bstop();  chk("R10", "stop read verdict", verdict_o, VL);
              chk("R10", "stop to active", bk(0), S_ACT);
    wr(0, 0);
    bstop();  chk("R10", "stop during write", verdict_o, VI);
    do_reset();
    act(0); rd(0, 1);
    bstop();  chk("R10", "stop read ap", verdict_o, VI);
  endtask

  task automatic t_ref_mrs();
    do_reset();
    mrs();    chk("R11", "mrs all idle", verdict_o, VL);
    refr();   chk("R11", "ref all idle", verdict_o, VL);
    act(3);
    mrs();    chk("R11", "mrs busy", verdict_o, VI);
    refr();   chk("R11", "ref busy", verdict_o, VI);
              chk("R11", "bank kept", bk(3), S_ACT);
  endtask

  task automatic t_cke();
    do_reset();
    ckel();   chk("R12", "cke low idle", verdict_o, VL);
    act(0); rd(0, 0);
    ckel();   chk("R12", "cke low in read", verdict_o, VI);
              chk("R12", "read kept", bk(0), S_RD);
    nop();    chk("R12", "burst ends", bk(0), S_ACT);
    ckel();   chk("R12", "cke low active", verdict_o, VL);
              chk("R12", "active kept", bk(0), S_ACT);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_desel_nop();
    t_read_flow();
    t_act_busy();
    t_write_rules();
    t_write_ap();
    t_pre();
    t_pall();
    t_bst();
    t_ref_mrs();
    t_cke();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule